// File: doc/BRIEF.md
# Atomic Swap Memory Arbiter

This block puts a small shared word store behind several requester ports and makes one operation indivisible: the swap. A swap writes the requester's value into the addressed word and hands back the value the word held just before, all in one storage cycle. No access from any other port can fall between that read and that write. Software builds spin locks on it. A word holding 0 is free and a word holding 1 is held. A requester swaps in 1 and looks at what comes back. If 0 comes back, it now owns the lock. If 1 comes back, it tries again later. To release the lock, the owner writes 0.

Plain reads, plain writes and a non-destructive probe go through the same arbiter, so every operation on the store is serialized with the swaps. Each port offers a request with a valid/ready handshake. A round-robin arbiter grants at most one port per cycle. The granted operation reaches the store on the next clock edge, and the following cycle carries a one-cycle response strobe back to that port. The strobe comes with the word's prior contents and a flag that tells whether the word was free.

Top module: `lswap_arbiter`

## Requirements
- R1: After reset, no response strobe and no ready is active, and every word of the store reads as 0.
- R2: In any cycle at most one port sees ready, and only a port whose valid is high can see ready.
- R3: Among the ports requesting, the grant goes to the first port found by counting upward (with wraparound) from the most recently granted port. After reset, port 0 comes first in that order.
- R4: A swap (opcode 2) stores the request's write value into the addressed word and returns the word's contents from before that store.
- R5: When every port issues a swap of value 1 on the same free word at once, exactly one of the responses reports that the word was free.
- R6: A read (opcode 0) returns the addressed word and leaves the store unchanged.
- R7: A write (opcode 1) stores the write value into the addressed word and returns the word's previous contents.
- R8: A probe (opcode 3) returns the addressed word and leaves it unchanged, whatever write value comes with it.
- R9: The response flag is high only on swap and probe responses whose returned word is 0. It is low for reads and writes.
- R10: Every handshake gives exactly one response strobe. The strobe is on the handshaking port's bit alone, in the cycle after the handshake, and no strobe appears without a handshake.
- R11: Once the lock holder writes 0 back, the next swap of 1 by another port reports the word free and takes the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | Request present, one bit per port |
| req_ready | output | NP | Request accepted this cycle, one bit per port |
| req_op | input | 2*NP | Opcode per port: 0 read, 1 write, 2 swap, 3 probe |
| req_addr | input | AW*NP | Word address per port |
| req_wdata | input | DW*NP | Value to store, per port |
| rsp_valid | output | NP | One-cycle response strobe, one bit per port |
| rsp_data | output | DW | Word contents before the access |
| rsp_flag | output | 1 | Returned word was 0 on a swap or probe |

## Verification
The hardest situation to reach is a true race: several ports swapping on the same free word in the very same cycle, so that the arbiter alone decides who wins. The bench raises all valids together on one address and then holds each one until its handshake. It predicts the grant order from the round-robin rule, checks each ready against that prediction, and counts the free flags that come back. A second round mixes all four opcodes on one word at the same moment, so every result depends on the order in which they were serialized.

// File: rtl/lswap_pkg.sv
`timescale 1ns/1ps
package lswap_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SWAP  = 2'd2,
        OP_TEST  = 2'd3
    } op_e;

    // operations that replace the addressed word
    function automatic logic op_stores(op_e o);
        return (o == OP_WRITE) || (o == OP_SWAP);
    endfunction

    // operations that report whether the word was free
    function automatic logic op_flags(op_e o);
        return (o == OP_SWAP) || (o == OP_TEST);
    endfunction

endpackage

// File: rtl/lswap_rr_arb.sv
`timescale 1ns/1ps
module lswap_rr_arb
    import lswap_pkg::*;
#(
    parameter int NP = 4,
    parameter int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    output logic [NP-1:0] gnt,
    output logic [IW-1:0] gnt_idx
);

    typedef struct packed {
        logic [IW-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        int   cand;
        logic found;
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        cand    = 0;
        for (int k = 1; k <= NP; k++) begin
            cand = int'(st_q.last) + k;
            if (cand >= NP) cand = cand - NP;
            if (!found && req[cand[IW-1:0]]) begin
                found             = 1'b1;
                gnt[cand[IW-1:0]] = 1'b1;
                gnt_idx           = cand[IW-1:0];
            end
        end
        if (found) st_d.last = gnt_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{last: IW'(NP - 1)};
        else        st_q <= st_d;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R2
    AST_GRANT_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R2

    for (genvar i = 0; i < NP; i++) begin : g_yield
        AST_RR_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(gnt[i]) && |(req & ~(NP'(1) << i))) |-> !gnt[i]); // R3
    end

endmodule

// File: rtl/lswap_bank.sv
`timescale 1ns/1ps
module lswap_bank
    import lswap_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  op_e           op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] old_word
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] words;
    } bank_st_t;

    bank_st_t st_d, st_q;

    // read of old contents and store of the new value share one edge
    always_comb begin
        st_d = st_q;
        if (en && op_stores(op)) st_d.words[addr] = wdata;
    end

    assign old_word = st_q.words[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STORE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_stores(op)) |=> st_q.words[$past(addr)] == $past(wdata)); // R4
    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !op_stores(op)) |=> st_q.words[$past(addr)] == $past(old_word)); // R8
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q)); // R6

endmodule

// File: rtl/lswap_arbiter.sv
`timescale 1ns/1ps
module lswap_arbiter
    import lswap_pkg::*;
#(
    parameter int NP    = 4,
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    req_valid,
    output logic [NP-1:0]    req_ready,
    input  logic [2*NP-1:0]  req_op,
    input  logic [AW*NP-1:0] req_addr,
    input  logic [DW*NP-1:0] req_wdata,
    output logic [NP-1:0]    rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic             rsp_flag
);

    localparam int IW = (NP > 1) ? $clog2(NP) : 1;

    typedef struct packed {
        logic [NP-1:0] vld;
        logic [DW-1:0] data;
        logic          flag;
    } rsp_st_t;

    logic [NP-1:0] gnt;
    logic [IW-1:0] gnt_idx;
    logic          fire;
    op_e           sel_op;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;
    logic [DW-1:0] old_word;
    rsp_st_t       rsp_d, rsp_q;

    lswap_rr_arb #(.NP(NP), .IW(IW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    assign fire      = |gnt;
    assign req_ready = gnt;

    always_comb begin
        sel_op    = op_e'(req_op[int'(gnt_idx)*2 +: 2]);
        sel_addr  = req_addr[int'(gnt_idx)*AW +: AW];
        sel_wdata = req_wdata[int'(gnt_idx)*DW +: DW];
    end

    lswap_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (fire),
        .op       (sel_op),
        .addr     (sel_addr),
        .wdata    (sel_wdata),
        .old_word (old_word)
    );

    always_comb begin
        rsp_d.vld  = gnt;
        rsp_d.data = fire ? old_word : '0;
        rsp_d.flag = fire && op_flags(sel_op) && (old_word == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_data  = rsp_q.data;
    assign rsp_flag  = rsp_q.flag;

    AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid)); // R10
    AST_RSP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> rsp_valid == $past(req_ready)); // R10
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_ready) |=> rsp_valid == '0); // R10
    AST_FLAG_MEANS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_flag |-> (|rsp_valid) && rsp_data == '0); // R9

endmodule

// File: tb/tb_lswap_arbiter.sv
`timescale 1ns/1ps
module tb_lswap_arbiter;

    localparam int NP    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    req_valid;
    logic [NP-1:0]    req_ready;
    logic [2*NP-1:0]  req_op;
    logic [AW*NP-1:0] req_addr;
    logic [DW*NP-1:0] req_wdata;
    logic [NP-1:0]    rsp_valid;
    logic [DW-1:0]    rsp_data;
    logic             rsp_flag;

    always #2.5 clk = ~clk;

    lswap_arbiter #(.NP(NP), .DW(DW), .DEPTH(DEPTH), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_flag(rsp_flag)
    );

    logic [NP-1:0] drv_valid = '0;
    logic [1:0]    b_op   [NP];
    logic [AW-1:0] b_addr [NP];
    logic [DW-1:0] b_wd   [NP];

    always_comb begin
        req_valid = drv_valid;
        for (int p = 0; p < NP; p++) begin
            req_op[p*2 +: 2]     = b_op[p];
            req_addr[p*AW +: AW] = b_addr[p];
            req_wdata[p*DW +: DW] = b_wd[p];
        end
    end

    typedef struct {
        int            port;
        logic [DW-1:0] data;
        logic          flag;
        string         tag;
    } exp_t;

    exp_t          sbq[$];
    logic [DW-1:0] model [DEPTH];
    int            last_gnt = NP - 1;
    int            n_chk = 0;
    int            n_fail = 0;
    int            acq_cnt = 0;
    int            won_port = 0;
    bit            mon_on = 1'b0;
    bit            done = 1'b0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // monitor: pops one expected item per response strobe
    always @(negedge clk) begin
        if (mon_on && rsp_valid != '0) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R10 unexpected strobe", 32'(rsp_valid), 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(rsp_valid == (NP'(1) << e.port), "R10 strobe port", 32'(rsp_valid), 32'(NP'(1) << e.port));
                chk(rsp_data == e.data, e.tag, 32'(rsp_data), 32'(e.data));
                chk(rsp_flag == e.flag, "R9 flag", 32'(rsp_flag), 32'(e.flag));
                if (rsp_flag) acq_cnt++;
            end
        end
    end

    task automatic setp(input int p, input logic [1:0] op, input int a, input int wd);
        b_op[p]   = op;
        b_addr[p] = AW'(a);
        b_wd[p]   = DW'(wd);
    endtask

    // driver: raise the masked valids together, predict grant order (R3)
    task automatic run_round(input logic [NP-1:0] mask);
        logic [NP-1:0] pending;
        pending = mask;
        @(negedge clk);
        drv_valid = pending;
        while (pending != '0) begin
            int   pred;
            exp_t e;
            logic [DW-1:0] old;
            pred = -1;
            #1;
            for (int k = 1; k <= NP; k++) begin
                int c;
                c = (last_gnt + k) % NP;
                if (pred < 0 && pending[c]) pred = c;
            end
            chk(req_ready == (NP'(1) << pred), "R3 grant order", 32'(req_ready), 32'(NP'(1) << pred));
            old    = model[b_addr[pred]];
            e.port = pred;
            e.data = old;
            e.flag = (b_op[pred] == 2'd2 || b_op[pred] == 2'd3) && old == '0;
            case (b_op[pred])
                2'd0:    e.tag = "R6 read data";
                2'd1:    e.tag = "R7 write old data";
                2'd2:    e.tag = "R4 swap old data";
                default: e.tag = "R8 probe data";
            endcase
            if (b_op[pred] == 2'd2 && e.flag) won_port = pred;
            sbq.push_back(e);
            if (b_op[pred] == 2'd1 || b_op[pred] == 2'd2) model[b_addr[pred]] = b_wd[pred];
            last_gnt = pred;
            @(negedge clk);
            pending[pred] = 1'b0;
            drv_valid = pending;
        end
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R10 all responses seen", 32'(sbq.size()), 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        int acq0;
        for (int p = 0; p < NP; p++) setp(p, 2'd0, 0, 0);
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == '0, "R1 no strobe in reset", 32'(rsp_valid), 32'h0);
        chk(req_ready == '0, "R1 no ready in reset", 32'(req_ready), 32'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        chk(rsp_valid == '0, "R1 no strobe after reset", 32'(rsp_valid), 32'h0);

        // R1: store cleared
        for (int a = 0; a < 4; a++) begin
            setp(0, 2'd0, a, 0);
            run_round(4'b0001);
        end
        // R7 then R6 twice
        setp(1, 2'd1, 3, 8'h5A); run_round(4'b0010);
        setp(2, 2'd0, 3, 0);     run_round(4'b0100);
        run_round(4'b0100);
        // R8: probe with a nonzero write value, then read back
        setp(0, 2'd3, 3, 8'hFF); run_round(4'b0001);
        setp(2, 2'd0, 3, 0);     run_round(4'b0100);
        setp(3, 2'd3, 9, 8'h77); run_round(4'b1000);
        setp(1, 2'd0, 9, 0);     run_round(4'b0010);
        // R4 / R9: take a lock, then fail to take it
        setp(3, 2'd2, 7, 1); run_round(4'b1000);
        setp(0, 2'd2, 7, 1); run_round(4'b0001);
        setp(1, 2'd0, 7, 0); run_round(4'b0010);
        drain();

        // R5: all ports race on one free word
        acq0 = acq_cnt;
        for (int p = 0; p < NP; p++) setp(p, 2'd2, 10, 1);
        run_round(4'b1111);
        drain();
        chk(acq_cnt - acq0 == 1, "R5 single winner", 32'(acq_cnt - acq0), 32'h1);

        // R11: holder releases, another port takes it
        acq0 = acq_cnt;
        setp(won_port, 2'd1, 10, 0); run_round(NP'(1) << won_port);
        setp((won_port + 1) % NP, 2'd2, 10, 1); run_round(NP'(1) << ((won_port + 1) % NP));
        drain();
        chk(acq_cnt - acq0 == 1, "R11 lock retaken", 32'(acq_cnt - acq0), 32'h1);

        // R3: mixed operations on one word, serialized in round-robin order
        setp(0, 2'd0, 12, 0);
        setp(1, 2'd1, 12, 8'h33);
        setp(2, 2'd2, 12, 8'h01);
        setp(3, 2'd3, 12, 8'hEE);
        run_round(4'b1111);
        setp(0, 2'd2, 12, 8'h01);
        setp(2, 2'd3, 12, 0);
        run_round(4'b0101);
        drain();
        finish_run();
    end

endmodule